// File: doc/BRIEF.md
# Integer Decode and Execute Stage

This block is the execute stage of a small 32-bit load/store integer core. Each cycle it accepts one 32-bit instruction word and the two register values that the register file has already read for it: the first source field and the second source field. It decodes the word, works out the arithmetic, logic, shift or compare result, and forms the base-plus-offset memory address for loads and stores. It also produces the controls that the stages after it need: destination register index, register write enable, memory read strobe, memory write strobe and the data to store.

Two instruction layouts are decoded. Both carry the opcode in bits 31:26, the first source index in bits 25:21 and the second register index in bits 20:16. The register layout adds a destination index in bits 15:11, a shift distance in bits 10:6 and a function code in bits 5:0. The immediate layout uses bits 15:0 as a 16-bit constant. Encodings that the stage does not recognise raise an illegal-instruction flag, and all side effects are held off. All outputs are registered, so a result appears on the clock edge after its instruction is presented. Branch and jump handling, the register file and the memories are outside this block.

Top module: `ixu_exec_stage`

## Requirements
- R1: While rst_n is low every output is zero, and it stays zero until the first clock edge with rst_n high.
- R2: Outputs are registered: changing the inputs does not alter any output before the next rising clock edge, and the results for an instruction appear on that edge.
- R3: With opcode 0x00, function 0x20 gives rs+rt and function 0x22 gives rs-rt, both modulo 2^32 with no trap; the destination is bits 15:11 and the register write enable is set.
- R4: With opcode 0x00, function 0x24 gives rs AND rt, 0x25 gives rs OR rt and 0x27 gives NOT(rs OR rt).
- R5: With opcode 0x00, function 0x00 shifts rt left, 0x02 shifts rt right with zero fill and 0x03 shifts rt right with sign fill, each by the distance in bits 10:6.
- R6: Function 0x2A under opcode 0x00 compares rs with rt, and opcode 0x0A compares rs with the sign-extended constant. Both comparisons are signed, and the result is 1 or 0 in bit 0 with bits 31:1 cleared.
- R7: Opcode 0x08 adds the sign-extended constant to rs (range -32768 to +32767). Opcodes 0x0C and 0x0D AND or OR rs with the zero-extended constant. All three write the register named in bits 20:16.
- R8: Opcode 0x0F yields the 16-bit constant in bits 31:16 and zeros in bits 15:0, written to the register named in bits 20:16.
- R9: Opcode 0x23 (load) puts rs plus the sign-extended constant on mem_addr_o and result_o and raises mem_rd_o, with the destination in bits 20:16. For every other opcode mem_addr_o is zero.
- R10: Opcode 0x2B (store) puts rs plus the sign-extended constant on mem_addr_o, raises mem_wr_o, leaves reg_we_o low and reports destination 0. store_data_o always carries the rt value of the instruction.
- R11: An instruction whose destination index is 0 leaves reg_we_o low. Its result is still reported.
- R12: Any opcode other than 0x00, 0x08, 0x0A, 0x0C, 0x0D, 0x0F, 0x23 and 0x2B, or opcode 0x00 with a function code outside the nine listed, raises illegal_o. It also forces reg_we_o, mem_rd_o and mem_wr_o low and makes result_o, mem_addr_o and dest_o zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 32 | Value of the register named in bits 25:21 |
| rt_val_i | input | 32 | Value of the register named in bits 20:16 |
| result_o | output | 32 | Execute result (the address for loads and stores) |
| mem_addr_o | output | 32 | Effective memory address, zero for non-memory operations |
| store_data_o | output | 32 | Data to store (the rt value) |
| dest_o | output | 5 | Destination register index |
| reg_we_o | output | 1 | Register write enable |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| illegal_o | output | 1 | Undefined encoding flag |

## Verification
Every result and control output is due exactly one rising edge after its instruction word and operands are presented. The bench drives each stimulus on a falling edge. Just after that it confirms the outputs still show the previous instruction, which covers R2. It then compares every output field against its own model at the next falling edge, half a period after the edge that loads them. Directed cases cover the wrap, sign-fill, sign-extension, zero-destination and illegal boundaries, and a seeded random stream covers the rest of the encoding space.

// File: rtl/ixu_pkg.sv
package ixu_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned REG_IDX_W = 5;
    localparam int unsigned IMM_W     = 16;
    localparam int unsigned SHAMT_W   = 5;
    localparam int unsigned OPC_W     = 6;
    localparam int unsigned FN_W      = 6;
    localparam int unsigned EXT_W     = WORD_W - IMM_W;

    // opcodes
    localparam logic [OPC_W-1:0] OPC_REG  = 6'h00;
    localparam logic [OPC_W-1:0] OPC_ADDI = 6'h08;
    localparam logic [OPC_W-1:0] OPC_SLTI = 6'h0A;
    localparam logic [OPC_W-1:0] OPC_ANDI = 6'h0C;
    localparam logic [OPC_W-1:0] OPC_ORI  = 6'h0D;
    localparam logic [OPC_W-1:0] OPC_LUI  = 6'h0F;
    localparam logic [OPC_W-1:0] OPC_LDW  = 6'h23;
    localparam logic [OPC_W-1:0] OPC_STW  = 6'h2B;

    // function codes under OPC_REG
    localparam logic [FN_W-1:0] FN_SHL  = 6'h00;
    localparam logic [FN_W-1:0] FN_SHRL = 6'h02;
    localparam logic [FN_W-1:0] FN_SHRA = 6'h03;
    localparam logic [FN_W-1:0] FN_ADD  = 6'h20;
    localparam logic [FN_W-1:0] FN_SUB  = 6'h22;
    localparam logic [FN_W-1:0] FN_AND  = 6'h24;
    localparam logic [FN_W-1:0] FN_OR   = 6'h25;
    localparam logic [FN_W-1:0] FN_NOR  = 6'h27;
    localparam logic [FN_W-1:0] FN_SLT  = 6'h2A;

    typedef enum logic [3:0] {
        ALU_ZERO,
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_NOR,
        ALU_SLT,
        ALU_SHL,
        ALU_SHRL,
        ALU_SHRA,
        ALU_HIGH
    } alu_op_e;

    typedef enum logic [1:0] {
        BSEL_REG,
        BSEL_SEXT,
        BSEL_ZEXT
    } bsel_e;

    typedef struct packed {
        alu_op_e                alu_op;
        bsel_e                  bsel;
        logic [REG_IDX_W-1:0]   dest;
        logic                   reg_we;
        logic                   mem_rd;
        logic                   mem_wr;
        logic                   is_mem;
        logic                   illegal;
    } ctrl_t;

    typedef struct packed {
        logic [WORD_W-1:0]      result;
        logic [WORD_W-1:0]      mem_addr;
        logic [WORD_W-1:0]      store_data;
        logic [REG_IDX_W-1:0]   dest;
        logic                   reg_we;
        logic                   mem_rd;
        logic                   mem_wr;
        logic                   illegal;
    } stage_out_t;

endpackage

// File: rtl/ixu_decode.sv
module ixu_decode
    import ixu_pkg::*;
(
    input  logic [OPC_W-1:0]     opc_i,
    input  logic [FN_W-1:0]      fn_i,
    input  logic [REG_IDX_W-1:0] rt_idx_i,
    input  logic [REG_IDX_W-1:0] rd_idx_i,
    output ctrl_t                ctrl_o
);

    ctrl_t c;
    logic  writes;

    always_comb begin
        c        = '0;
        c.alu_op = ALU_ZERO;
        c.bsel   = BSEL_REG;
        writes   = 1'b0;

        case (opc_i)
            OPC_REG: begin
                c.dest = rd_idx_i;
                writes = 1'b1;
                case (fn_i)
                    FN_ADD:  c.alu_op = ALU_ADD;
                    FN_SUB:  c.alu_op = ALU_SUB;
                    FN_AND:  c.alu_op = ALU_AND;
                    FN_OR:   c.alu_op = ALU_OR;
                    FN_NOR:  c.alu_op = ALU_NOR;
                    FN_SLT:  c.alu_op = ALU_SLT;
                    FN_SHL:  c.alu_op = ALU_SHL;
                    FN_SHRL: c.alu_op = ALU_SHRL;
                    FN_SHRA: c.alu_op = ALU_SHRA;
                    default: c.illegal = 1'b1;
                endcase
            end
            OPC_ADDI: begin
                c.alu_op = ALU_ADD;
                c.bsel   = BSEL_SEXT;
                c.dest   = rt_idx_i;
                writes   = 1'b1;
            end
            OPC_SLTI: begin
                c.alu_op = ALU_SLT;
                c.bsel   = BSEL_SEXT;
                c.dest   = rt_idx_i;
                writes   = 1'b1;
            end
            OPC_ANDI: begin
                c.alu_op = ALU_AND;
                c.bsel   = BSEL_ZEXT;
                c.dest   = rt_idx_i;
                writes   = 1'b1;
            end
            OPC_ORI: begin
                c.alu_op = ALU_OR;
                c.bsel   = BSEL_ZEXT;
                c.dest   = rt_idx_i;
                writes   = 1'b1;
            end
            OPC_LUI: begin
                c.alu_op = ALU_HIGH;
                c.bsel   = BSEL_ZEXT;
                c.dest   = rt_idx_i;
                writes   = 1'b1;
            end
            OPC_LDW: begin
                c.alu_op = ALU_ADD;
                c.bsel   = BSEL_SEXT;
                c.dest   = rt_idx_i;
                c.mem_rd = 1'b1;
                c.is_mem = 1'b1;
                writes   = 1'b1;
            end
            OPC_STW: begin
                c.alu_op = ALU_ADD;
                c.bsel   = BSEL_SEXT;
                c.mem_wr = 1'b1;
                c.is_mem = 1'b1;
            end
            default: c.illegal = 1'b1;
        endcase

        if (c.illegal) begin
            c.alu_op = ALU_ZERO;
            c.dest   = '0;
            c.mem_rd = 1'b0;
            c.mem_wr = 1'b0;
            c.is_mem = 1'b0;
            writes   = 1'b0;
        end

        // register 0 is hard-wired: never write it
        c.reg_we = writes && (c.dest != '0);
    end

    assign ctrl_o = c;

endmodule

// File: rtl/ixu_operand.sv
module ixu_operand
    import ixu_pkg::*;
(
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [WORD_W-1:0] rt_val_i,
    input  bsel_e             bsel_i,
    output logic [WORD_W-1:0] imm_sext_o,
    output logic [WORD_W-1:0] b_o
);

    logic [WORD_W-1:0] imm_zext;

    assign imm_sext_o = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    assign imm_zext   = {{EXT_W{1'b0}}, imm_i};

    always_comb begin
        case (bsel_i)
            BSEL_SEXT: b_o = imm_sext_o;
            BSEL_ZEXT: b_o = imm_zext;
            default:   b_o = rt_val_i;
        endcase
    end

endmodule

// File: rtl/ixu_alu.sv
module ixu_alu
    import ixu_pkg::*;
(
    input  alu_op_e            op_i,
    input  logic [WORD_W-1:0]  a_i,
    input  logic [WORD_W-1:0]  b_i,
    input  logic [SHAMT_W-1:0] shamt_i,
    output logic [WORD_W-1:0]  y_o
);

    logic              lt;
    logic [WORD_W-1:0] sum;
    logic [WORD_W-1:0] diff;

    assign sum  = a_i + b_i;
    assign diff = a_i - b_i;
    assign lt   = $signed(a_i) < $signed(b_i);

    always_comb begin
        case (op_i)
            ALU_ADD:  y_o = sum;
            ALU_SUB:  y_o = diff;
            ALU_AND:  y_o = a_i & b_i;
            ALU_OR:   y_o = a_i | b_i;
            ALU_NOR:  y_o = ~(a_i | b_i);
            ALU_SLT:  y_o = {{(WORD_W-1){1'b0}}, lt};
            ALU_SHL:  y_o = b_i << shamt_i;
            ALU_SHRL: y_o = b_i >> shamt_i;
            ALU_SHRA: y_o = $unsigned($signed(b_i) >>> shamt_i);
            ALU_HIGH: y_o = {b_i[IMM_W-1:0], {EXT_W{1'b0}}};
            default:  y_o = '0;
        endcase
    end

endmodule

// File: rtl/ixu_agu.sv
module ixu_agu
    import ixu_pkg::*;
(
    input  logic              en_i,
    input  logic [WORD_W-1:0] base_i,
    input  logic [WORD_W-1:0] offset_i,
    output logic [WORD_W-1:0] addr_o
);

    assign addr_o = en_i ? (base_i + offset_i) : '0;

endmodule

// File: rtl/ixu_exec_stage.sv
module ixu_exec_stage
    import ixu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WORD_W-1:0]    instr_i,
    input  logic [WORD_W-1:0]    rs_val_i,
    input  logic [WORD_W-1:0]    rt_val_i,
    output logic [WORD_W-1:0]    result_o,
    output logic [WORD_W-1:0]    mem_addr_o,
    output logic [WORD_W-1:0]    store_data_o,
    output logic [REG_IDX_W-1:0] dest_o,
    output logic                 reg_we_o,
    output logic                 mem_rd_o,
    output logic                 mem_wr_o,
    output logic                 illegal_o
);

    localparam int unsigned OPC_LSB   = WORD_W - OPC_W;
    localparam int unsigned RS_LSB    = OPC_LSB - REG_IDX_W;
    localparam int unsigned RT_LSB    = RS_LSB - REG_IDX_W;
    localparam int unsigned RD_LSB    = RT_LSB - REG_IDX_W;
    localparam int unsigned SHAMT_LSB = RD_LSB - SHAMT_W;

    logic [OPC_W-1:0]     opc;
    logic [FN_W-1:0]      fn;
    logic [REG_IDX_W-1:0] rt_idx;
    logic [REG_IDX_W-1:0] rd_idx;
    logic [SHAMT_W-1:0]   shamt;
    logic [IMM_W-1:0]     imm;

    assign opc    = instr_i[WORD_W-1:OPC_LSB];
    assign rt_idx = instr_i[RS_LSB-1:RT_LSB];
    assign rd_idx = instr_i[RT_LSB-1:RD_LSB];
    assign shamt  = instr_i[RD_LSB-1:SHAMT_LSB];
    assign fn     = instr_i[FN_W-1:0];
    assign imm    = instr_i[IMM_W-1:0];

    ctrl_t             ctrl;
    logic [WORD_W-1:0] imm_sext;
    logic [WORD_W-1:0] opnd_b;
    logic [WORD_W-1:0] alu_y;
    logic [WORD_W-1:0] ea;

    ixu_decode u_decode (
        .opc_i    (opc),
        .fn_i     (fn),
        .rt_idx_i (rt_idx),
        .rd_idx_i (rd_idx),
        .ctrl_o   (ctrl)
    );

    ixu_operand u_operand (
        .imm_i      (imm),
        .rt_val_i   (rt_val_i),
        .bsel_i     (ctrl.bsel),
        .imm_sext_o (imm_sext),
        .b_o        (opnd_b)
    );

    ixu_alu u_alu (
        .op_i    (ctrl.alu_op),
        .a_i     (rs_val_i),
        .b_i     (opnd_b),
        .shamt_i (shamt),
        .y_o     (alu_y)
    );

    ixu_agu u_agu (
        .en_i     (ctrl.is_mem),
        .base_i   (rs_val_i),
        .offset_i (imm_sext),
        .addr_o   (ea)
    );

    stage_out_t out_d;
    stage_out_t out_q;

    always_comb begin
        out_d            = '0;
        out_d.result     = alu_y;
        out_d.mem_addr   = ea;
        out_d.store_data = rt_val_i;
        out_d.dest       = ctrl.dest;
        out_d.reg_we     = ctrl.reg_we;
        out_d.mem_rd     = ctrl.mem_rd;
        out_d.mem_wr     = ctrl.mem_wr;
        out_d.illegal    = ctrl.illegal;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign result_o     = out_q.result;
    assign mem_addr_o   = out_q.mem_addr;
    assign store_data_o = out_q.store_data;
    assign dest_o       = out_q.dest;
    assign reg_we_o     = out_q.reg_we;
    assign mem_rd_o     = out_q.mem_rd;
    assign mem_wr_o     = out_q.mem_wr;
    assign illegal_o    = out_q.illegal;

    // R12: an undefined word has no side effect
    a_r12_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!reg_we_o && !mem_rd_o && !mem_wr_o && result_o == '0));

    // R11: register 0 is never a write target
    a_r11_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |-> (dest_o != '0));

    // R10: a store never writes the register file and never reads memory
    a_r10_store_only: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> (!reg_we_o && !mem_rd_o));

    // R9: the address output is quiet for non-memory work
    a_r9_addr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_o && !mem_wr_o) |-> (mem_addr_o == '0));

    // R8: load-upper places the constant in the high half
    a_r8_upper_half: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(instr_i[WORD_W-1:OPC_LSB]) == OPC_LUI)
        |-> (result_o == {$past(instr_i[IMM_W-1:0]), {EXT_W{1'b0}}}));

    // R6: compare results occupy bit 0 only
    a_r6_flag_only: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(instr_i[WORD_W-1:OPC_LSB]) == OPC_SLTI)
        |-> (result_o[WORD_W-1:1] == '0));

    // R10: store data follows the rt operand one edge later
    a_r10_store_data: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (store_data_o == $past(rt_val_i)));

endmodule

// File: tb/tb_ixu_exec_stage.sv
module tb_ixu_exec_stage;

    logic        clk;
    logic        rst_n;
    logic [31:0] instr_i;
    logic [31:0] rs_val_i;
    logic [31:0] rt_val_i;
    logic [31:0] result_o;
    logic [31:0] mem_addr_o;
    logic [31:0] store_data_o;
    logic [4:0]  dest_o;
    logic        reg_we_o;
    logic        mem_rd_o;
    logic        mem_wr_o;
    logic        illegal_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    ixu_exec_stage dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .instr_i      (instr_i),
        .rs_val_i     (rs_val_i),
        .rt_val_i     (rt_val_i),
        .result_o     (result_o),
        .mem_addr_o   (mem_addr_o),
        .store_data_o (store_data_o),
        .dest_o       (dest_o),
        .reg_we_o     (reg_we_o),
        .mem_rd_o     (mem_rd_o),
        .mem_wr_o     (mem_wr_o),
        .illegal_o    (illegal_o)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    typedef struct packed {
        logic [31:0] res;
        logic [31:0] addr;
        logic [31:0] sdata;
        logic [4:0]  dst;
        logic        we;
        logic        rd;
        logic        wr;
        logic        ill;
    } obs_t;

    obs_t prev_exp;

    function automatic obs_t model(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
        obs_t e;
        logic [5:0]  op;
        logic [5:0]  fn;
        logic [4:0]  sh;
        logic [31:0] se;
        logic [31:0] ze;
        logic        wr_reg;
        op = ins[31:26];
        fn = ins[5:0];
        sh = ins[10:6];
        se = {{16{ins[15]}}, ins[15:0]};
        ze = {16'h0000, ins[15:0]};
        e = '0;
        e.sdata = b;
        wr_reg = 1'b1;
        case (op)
            6'h00: begin
                e.dst = ins[15:11];
                case (fn)
                    6'h20: e.res = a + b;
                    6'h22: e.res = a - b;
                    6'h24: e.res = a & b;
                    6'h25: e.res = a | b;
                    6'h27: e.res = ~(a | b);
                    6'h2A: e.res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                    6'h00: e.res = b << sh;
                    6'h02: e.res = b >> sh;
                    6'h03: e.res = $unsigned($signed(b) >>> sh);
                    default: e.ill = 1'b1;
                endcase
            end
            6'h08: begin e.dst = ins[20:16]; e.res = a + se; end
            6'h0A: begin e.dst = ins[20:16]; e.res = ($signed(a) < $signed(se)) ? 32'd1 : 32'd0; end
            6'h0C: begin e.dst = ins[20:16]; e.res = a & ze; end
            6'h0D: begin e.dst = ins[20:16]; e.res = a | ze; end
            6'h0F: begin e.dst = ins[20:16]; e.res = {ins[15:0], 16'h0000}; end
            6'h23: begin e.dst = ins[20:16]; e.res = a + se; e.addr = a + se; e.rd = 1'b1; end
            6'h2B: begin e.res = a + se; e.addr = a + se; e.wr = 1'b1; wr_reg = 1'b0; end
            default: e.ill = 1'b1;
        endcase
        if (e.ill) begin
            e.res = '0; e.dst = '0; e.addr = '0; e.rd = 1'b0; e.wr = 1'b0; wr_reg = 1'b0;
        end
        e.we = wr_reg && (e.dst != 5'd0);
        return e;
    endfunction

    function automatic string tag_of(input logic [31:0] ins);
        logic [5:0] op;
        logic [5:0] fn;
        obs_t       e;
        op = ins[31:26];
        fn = ins[5:0];
        e  = model(ins, 32'h0, 32'h0);
        if (e.ill)                           return "R12";
        if (op != 6'h2B && e.dst == 5'd0)    return "R11";
        case (op)
            6'h00: begin
                if (fn == 6'h20 || fn == 6'h22) return "R3";
                if (fn == 6'h2A)                return "R6";
                if (fn[5])                      return "R4";
                return "R5";
            end
            6'h0A:   return "R6";
            6'h0F:   return "R8";
            6'h23:   return "R9";
            6'h2B:   return "R10";
            default: return "R7";
        endcase
    endfunction

    function automatic obs_t observed();
        obs_t o;
        o.res   = result_o;
        o.addr  = mem_addr_o;
        o.sdata = store_data_o;
        o.dst   = dest_o;
        o.we    = reg_we_o;
        o.rd    = mem_rd_o;
        o.wr    = mem_wr_o;
        o.ill   = illegal_o;
        return o;
    endfunction

    task automatic compare(input string tag, input obs_t got, input obs_t exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got res=%h addr=%h sd=%h dst=%0d we=%b rd=%b wr=%b ill=%b exp res=%h addr=%h sd=%h dst=%0d we=%b rd=%b wr=%b ill=%b",
                     tag, got.res, got.addr, got.sdata, got.dst, got.we, got.rd, got.wr, got.ill,
                     exp.res, exp.addr, exp.sdata, exp.dst, exp.we, exp.rd, exp.wr, exp.ill);
        end
    endtask

    // called on a falling edge; returns on the next falling edge
    task automatic run(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
        obs_t e;
        instr_i  = ins;
        rs_val_i = a;
        rt_val_i = b;
        e = model(ins, a, b);
        #1;
        compare("R2 hold-until-edge", observed(), prev_exp);
        @(negedge clk);
        compare(tag_of(ins), observed(), e);
        prev_exp = e;
    endtask

    function automatic logic [31:0] rtype(input logic [4:0] rs, input logic [4:0] rt, input logic [4:0] rd,
                                          input logic [4:0] sh, input logic [5:0] fn);
        return {6'h00, rs, rt, rd, sh, fn};
    endfunction

    function automatic logic [31:0] itype(input logic [5:0] op, input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [5:0] ops [10];
        logic [5:0] fns [9];
        ops = '{6'h00, 6'h00, 6'h08, 6'h0A, 6'h0C, 6'h0D, 6'h0F, 6'h23, 6'h2B, 6'h00};
        fns = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h27, 6'h2A, 6'h00, 6'h02, 6'h03};
        void'($urandom(32'h5EED_1234));

        rst_n = 1'b0;
        instr_i = 32'h0;
        rs_val_i = 32'hDEAD_BEEF;
        rt_val_i = 32'hCAFE_F00D;
        prev_exp = '0;
        repeat (3) @(negedge clk);
        compare("R1 reset", observed(), '0);
        instr_i = itype(6'h23, 5'd1, 5'd2, 16'h0010);
        @(negedge clk);
        compare("R1 reset holds", observed(), '0);
        rst_n = 1'b1;

        // directed corners
        run(rtype(5'd8, 5'd9, 5'd10, 5'd0, 6'h20), 32'h7FFF_FFFF, 32'h0000_0001);      // R3 wrap
        run(rtype(5'd8, 5'd9, 5'd10, 5'd0, 6'h22), 32'h0000_0000, 32'h0000_0001);      // R3 borrow
        run(rtype(5'd1, 5'd2, 5'd3, 5'd0, 6'h27), 32'hF0F0_0000, 32'h0000_0F0F);       // R4 nor
        run(rtype(5'd1, 5'd2, 5'd3, 5'd31, 6'h00), 32'h0, 32'h0000_0003);              // R5 left 31
        run(rtype(5'd1, 5'd2, 5'd3, 5'd4, 6'h02), 32'h0, 32'h8000_0000);               // R5 zero fill
        run(rtype(5'd1, 5'd2, 5'd3, 5'd4, 6'h03), 32'h0, 32'h8000_0000);               // R5 sign fill
        run(rtype(5'd1, 5'd2, 5'd3, 5'd0, 6'h2A), 32'hFFFF_FFFF, 32'h0000_0001);       // R6 signed
        run(rtype(5'd1, 5'd2, 5'd3, 5'd0, 6'h2A), 32'h0000_0001, 32'hFFFF_FFFF);       // R6 signed
        run(itype(6'h0A, 5'd4, 5'd5, 16'h8000), 32'hFFFF_8001, 32'h0);                 // R6 slti
        run(itype(6'h08, 5'd4, 5'd5, 16'hFFFF), 32'h0000_0000, 32'h0);                 // R7 sext -1
        run(itype(6'h08, 5'd4, 5'd5, 16'h7FFF), 32'h0000_0001, 32'h0);                 // R7 max
        run(itype(6'h0C, 5'd4, 5'd5, 16'hFF00), 32'hFFFF_FFFF, 32'h0);                 // R7 andi zext
        run(itype(6'h0D, 5'd4, 5'd5, 16'h8000), 32'h0000_0000, 32'h0);                 // R7 ori zext
        run(itype(6'h0F, 5'd0, 5'd6, 16'hFFFF), 32'h1234_5678, 32'h0);                 // R8
        run(itype(6'h23, 5'd18, 5'd8, 16'h0018), 32'h1200_4094, 32'h0);                // R9
        run(itype(6'h23, 5'd18, 5'd8, 16'hFFF8), 32'h0000_0004, 32'h0);                // R9 negative
        run(itype(6'h2B, 5'd18, 5'd8, 16'h0020), 32'h0000_1000, 32'hA5A5_5A5A);        // R10
        run(rtype(5'd1, 5'd2, 5'd0, 5'd0, 6'h20), 32'h5, 32'h6);                       // R11 rd=0
        run(itype(6'h23, 5'd1, 5'd0, 16'h0004), 32'h100, 32'h0);                       // R11 load to 0
        run(itype(6'h3F, 5'd1, 5'd2, 16'h1234), 32'h100, 32'h200);                     // R12 bad opcode
        run(rtype(5'd1, 5'd2, 5'd3, 5'd0, 6'h01), 32'h100, 32'h200);                   // R12 bad funct
        run(itype(6'h04, 5'd1, 5'd2, 16'h0004), 32'h100, 32'h100);                     // R12 branch code

        // seeded random stream
        for (int i = 0; i < 600; i++) begin
            logic [31:0] ins;
            ins = $urandom;
            if (($urandom % 8) != 0) begin
                ins[31:26] = ops[$urandom % 10];
                if (ins[31:26] == 6'h00 && ($urandom % 6) != 0)
                    ins[5:0] = fns[$urandom % 9];
            end
            run(ins, $urandom, $urandom);
        end

        // reset again mid-stream
        rst_n = 1'b0;
        @(negedge clk);
        compare("R1 re-reset", observed(), '0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule